// File: doc/BRIEF.md
# Consumer digital audio channel-status bit generator

This block produces the channel-status bit that rides in every subframe of an IEC958 / S/PDIF consumer-format output. At the start of each 192-frame block it captures one 32-bit status word per channel. Over the first 32 frames of the block it sends that word one bit per frame, least-significant bit first. The C bit is 0 for every later frame of the block. The biphase coder, the preamble logic and the parity logic sit around it and take `cbit_o` for the subframe named by `right_i`.

The status word is made of several kinds of field:

- Constants: the consumer flag, the mode, the source number and the clock accuracy.
- A payload-type flag.
- A channel-number field that differs between the left and right subframes.
- A sampling-rate code.
- Copyright, emphasis and category fields. Each of these comes from the decoded stream or from a built-in default, unless the host sets that field's override enable. In that case the host value is used.

Every input is sampled only on a block-start strobe. The word stays fixed for the rest of the block.

A small sequencer tracks the block position and has three named states:

- `SEQ_IDLE`: no block has started since reset.
- `SEQ_STAT`: frames 0 to 31, where the status bits are sent.
- `SEQ_PAD`: frames 32 to 191, where the C bit is 0.

The transitions are:

- `start`: block-start strobe, from any state to `SEQ_STAT`, with the frame index cleared to 0.
- `advance`: frame strobe in `SEQ_STAT`, which increments the index.
- `status_done`: frame strobe in `SEQ_STAT` at index 31, which goes to `SEQ_PAD`.
- `pad_count`: frame strobe in `SEQ_PAD`, which increments the index and saturates at 191.
- `idle_hold`: frame strobe in `SEQ_IDLE`, which changes nothing.

Top module: `chstat_gen`

## Requirements
- R1: `cbit_o` is 0 in every frame with index 32 or higher in a block, including after the frame index saturates at 191. It is also 0 for any frame strobe that arrives before the first block-start strobe.
- R2: In the status word, bit 0 (consumer flag) is 0 and bits 6 and 7 (mode) are 0. Bit 1 equals `nonaudio_i`.
- R3: Bit 2 is the copyright flag and bits 3 to 5 carry the emphasis code, with bit 3+k equal to emphasis bit k. Each value comes from `strm_copy_i` / `strm_emph_i`. When `ovr_copy_i` / `ovr_emph_i` is 1, the value comes from `host_copy_i` / `host_emph_i` instead.
- R4: Bits 8 to 15 carry the category code, with bit 8+k equal to category bit k. The code is 8'b1001_1000 when `fmt_mode_i` is 1 and 8'b0000_0000 when it is 0. When `ovr_cat_i` is 1, the code is `host_cat_i`.
- R5: Bits 16 to 19 (source number) are 0. On the left subframe (`right_i`=0) bit 20 is 1, and on the right subframe bit 21 is 1. The other bits of 20 to 23 are 0. When `chan_dc_i` is 1, bits 20 to 23 are all 0.
- R6: The rate code in `rate_sel_i` sets bits 24 to 27. Code 1 (48 kHz) sets bit 25 only. Code 2 (32 kHz) sets bits 24 and 25. Code 0 (44.1 kHz) and the unused code 3 set none of these bits. Bit 29 is 1. Bits 28, 30 and 31 are 0.
- R7: The frame in which `blk_start_i` is strobed is frame 0. Each later `frame_i` strobe advances the index by one. In frame n (n below 32), `cbit_o` is bit n of that channel's word, from the clock edge of the strobe until the next strobe.
- R8: The status word is captured only on `blk_start_i`. Changes to any field input in the middle of a block do not affect `cbit_o` until the next block start.
- R9: A `blk_start_i` strobe before frame 191 restarts the block at frame 0 with a newly captured word.
- R10: While `rst_n` is low and after it is released, `cbit_o` is 0 and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start_i | input | 1 | Strobe marking frame 0 of a block; also latches the status words |
| frame_i | input | 1 | Strobe marking the start of each later frame |
| right_i | input | 1 | Subframe being serialised: 0 left, 1 right |
| rate_sel_i | input | 2 | Sampling rate: 0 = 44.1 kHz, 1 = 48 kHz, 2 = 32 kHz |
| nonaudio_i | input | 1 | 1 = non-audio data payload, 0 = linear PCM |
| chan_dc_i | input | 1 | Channel number treated as don't-care |
| fmt_mode_i | input | 1 | Selects the default category code (1 = formatter code) |
| strm_copy_i | input | 1 | Copyright flag from the stream |
| strm_emph_i | input | 3 | Emphasis code from the stream |
| ovr_copy_i | input | 1 | Host override enable for copyright |
| host_copy_i | input | 1 | Host copyright value |
| ovr_emph_i | input | 1 | Host override enable for emphasis |
| host_emph_i | input | 3 | Host emphasis value |
| ovr_cat_i | input | 1 | Host override enable for category |
| host_cat_i | input | 8 | Host category value |
| cbit_o | output | 1 | Channel-status bit for the current subframe |

## Verification
The bench randomises every field input at each block start. This separates each field's bit positions, and each stream-versus-host and default-category choice, from its neighbours. It also reads both subframes of every frame, which separates the left channel-number field from the right one.

Two further patterns change the field inputs in the middle of a block. One changes them without a block start, which shows whether the captured word stays frozen. The other changes them together with an early block start, which shows whether a restart captures a fresh word and clears the index. Full-length blocks run past frame 191, and frames are strobed before the first block start. These show whether the C bit stays at 0 in the padding region, at saturation, and while the sequencer is idle.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

    localparam int STAT_BITS = 32;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_STAT = 2'd1,
        SEQ_PAD  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        RATE_44K1 = 2'd0,
        RATE_48K  = 2'd1,
        RATE_32K  = 2'd2,
        RATE_RSVD = 2'd3
    } rate_t;

    localparam logic [7:0] CAT_FORMATTER = 8'b1001_1000;
    localparam logic [7:0] CAT_DECODER   = 8'b0000_0000;

endpackage

// File: rtl/chstat_word.sv
module chstat_word
    import chstat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [1:0]           rate_sel_i,
    input  logic                 nonaudio_i,
    input  logic                 chan_dc_i,
    input  logic                 fmt_mode_i,
    input  logic                 strm_copy_i,
    input  logic [2:0]           strm_emph_i,
    input  logic                 ovr_copy_i,
    input  logic                 host_copy_i,
    input  logic                 ovr_emph_i,
    input  logic [2:0]           host_emph_i,
    input  logic                 ovr_cat_i,
    input  logic [7:0]           host_cat_i,
    output logic [STAT_BITS-1:0] word_l_o,
    output logic [STAT_BITS-1:0] word_r_o
);

    logic       copy_sel;
    logic [2:0] emph_sel;
    logic [7:0] cat_sel;
    logic [3:0] rate_code;

    always_comb begin
        copy_sel = ovr_copy_i ? host_copy_i : strm_copy_i;
        emph_sel = ovr_emph_i ? host_emph_i : strm_emph_i;
        if (ovr_cat_i)
            cat_sel = host_cat_i;
        else
            cat_sel = fmt_mode_i ? CAT_FORMATTER : CAT_DECODER;
        unique case (rate_t'(rate_sel_i))
            RATE_48K:  rate_code = 4'b0010;
            RATE_32K:  rate_code = 4'b0011;
            RATE_44K1: rate_code = 4'b0000;
            RATE_RSVD: rate_code = 4'b0000;
        endcase
    end

    logic [STAT_BITS-1:0] word_q [2];

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [3:0]           chan_code;
        logic [STAT_BITS-1:0] word_d;

        assign chan_code = chan_dc_i ? 4'b0000 : ((ch == 0) ? 4'b0001 : 4'b0010);

        always_comb begin
            word_d        = '0;
            word_d[1]     = nonaudio_i;
            word_d[2]     = copy_sel;
            word_d[5:3]   = emph_sel;
            word_d[15:8]  = cat_sel;
            word_d[23:20] = chan_code;
            word_d[27:24] = rate_code;
            word_d[29]    = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[ch] <= '0;
            else if (load_i)
                word_q[ch] <= word_d;
        end
    end

    assign word_l_o = word_q[0];
    assign word_r_o = word_q[1];

endmodule

// File: rtl/chstat_seq.sv
module chstat_seq
    import chstat_pkg::*;
#(
    parameter int NFRAMES = 192,
    parameter int NSTAT   = STAT_BITS,
    localparam int CW     = $clog2(NFRAMES),
    localparam logic [CW-1:0] LAST_IDX = CW'(NFRAMES - 1),
    localparam logic [CW-1:0] STAT_END = CW'(NSTAT - 1)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_start_i,
    input  logic          frame_i,
    output seq_state_t    state_o,
    output logic [CW-1:0] idx_o
);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (blk_start_i) begin
            state_d = SEQ_STAT;
            idx_d   = '0;
        end else if (frame_i) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    state_d = SEQ_IDLE;
                end
                SEQ_STAT: begin
                    idx_d = idx_q + CW'(1);
                    if (idx_q == STAT_END)
                        state_d = SEQ_PAD;
                end
                SEQ_PAD: begin
                    if (idx_q != LAST_IDX)
                        idx_d = idx_q + CW'(1);
                end
                default: begin
                    state_d = SEQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/chstat_gen.sv
module chstat_gen
    import chstat_pkg::*;
#(
    parameter int NFRAMES = 192,
    localparam int CW     = $clog2(NFRAMES),
    localparam int BW     = $clog2(STAT_BITS)
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_start_i,
    input  logic       frame_i,
    input  logic       right_i,
    input  logic [1:0] rate_sel_i,
    input  logic       nonaudio_i,
    input  logic       chan_dc_i,
    input  logic       fmt_mode_i,
    input  logic       strm_copy_i,
    input  logic [2:0] strm_emph_i,
    input  logic       ovr_copy_i,
    input  logic       host_copy_i,
    input  logic       ovr_emph_i,
    input  logic [2:0] host_emph_i,
    input  logic       ovr_cat_i,
    input  logic [7:0] host_cat_i,
    output logic       cbit_o
);

    seq_state_t           seq_state;
    logic [CW-1:0]        frame_idx;
    logic [STAT_BITS-1:0] word_l;
    logic [STAT_BITS-1:0] word_r;

    chstat_seq #(.NFRAMES(NFRAMES), .NSTAT(STAT_BITS)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_start_i (blk_start_i),
        .frame_i     (frame_i),
        .state_o     (seq_state),
        .idx_o       (frame_idx)
    );

    chstat_word i_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (blk_start_i),
        .rate_sel_i  (rate_sel_i),
        .nonaudio_i  (nonaudio_i),
        .chan_dc_i   (chan_dc_i),
        .fmt_mode_i  (fmt_mode_i),
        .strm_copy_i (strm_copy_i),
        .strm_emph_i (strm_emph_i),
        .ovr_copy_i  (ovr_copy_i),
        .host_copy_i (host_copy_i),
        .ovr_emph_i  (ovr_emph_i),
        .host_emph_i (host_emph_i),
        .ovr_cat_i   (ovr_cat_i),
        .host_cat_i  (host_cat_i),
        .word_l_o    (word_l),
        .word_r_o    (word_r)
    );

    logic [BW-1:0] bit_sel;
    assign bit_sel = frame_idx[BW-1:0];

    always_comb begin
        unique case (seq_state)
            SEQ_STAT: cbit_o = right_i ? word_r[bit_sel] : word_l[bit_sel];
            SEQ_IDLE: cbit_o = 1'b0;
            SEQ_PAD:  cbit_o = 1'b0;
            default:  cbit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/chstat_chk.sv
module chstat_chk
    import chstat_pkg::*;
#(
    parameter int NFRAMES = 192,
    localparam int CW     = $clog2(NFRAMES)
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 blk_start_i,
    input logic                 frame_i,
    input logic                 cbit_o,
    input seq_state_t           seq_state,
    input logic [CW-1:0]        frame_idx,
    input logic [STAT_BITS-1:0] word_l,
    input logic [STAT_BITS-1:0] word_r
);

    // R1
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SEQ_STAT) |-> !cbit_o);

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(frame_idx) <= NFRAMES - 1));

    // R2
    consumer_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_STAT && frame_idx == '0) |-> !cbit_o);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start_i |=> (seq_state == SEQ_STAT && frame_idx == '0));

    // R7
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && !blk_start_i && seq_state == SEQ_STAT)
            |=> (frame_idx == $past(frame_idx) + CW'(1)));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_start_i |=> ($stable(word_l) && $stable(word_r)));

endmodule

bind chstat_gen chstat_chk #(.NFRAMES(NFRAMES)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start_i (blk_start_i),
    .frame_i     (frame_i),
    .cbit_o      (cbit_o),
    .seq_state   (seq_state),
    .frame_idx   (frame_idx),
    .word_l      (word_l),
    .word_r      (word_r)
);

// File: tb/test_chstat_gen.sv
`timescale 1ns/100ps
module test_chstat_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_start_i = 1'b0, frame_i = 1'b0, right_i = 1'b0;
    logic [1:0] rate_sel_i = '0;
    logic       nonaudio_i = 0, chan_dc_i = 0, fmt_mode_i = 0;
    logic       strm_copy_i = 0, ovr_copy_i = 0, host_copy_i = 0;
    logic [2:0] strm_emph_i = '0, host_emph_i = '0;
    logic       ovr_emph_i = 0, ovr_cat_i = 0;
    logic [7:0] host_cat_i = '0;
    logic       cbit_o;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    chstat_gen i_chstat_gen (.*);

    // bench model
    bit        m_valid = 0;
    int        m_idx = 0;
    bit [31:0] m_wl, m_wr;
    string     m_tag = "R7";

    function automatic bit [31:0] exp_word(bit right);
        bit [31:0] w = '0;
        bit [7:0]  cat;
        w[1] = nonaudio_i;
        w[2] = ovr_copy_i ? host_copy_i : strm_copy_i;
        for (int k = 0; k < 3; k++) w[3+k] = ovr_emph_i ? host_emph_i[k] : strm_emph_i[k];
        cat = ovr_cat_i ? host_cat_i : (fmt_mode_i ? 8'h98 : 8'h00);
        for (int k = 0; k < 8; k++) w[8+k] = cat[k];
        if (!chan_dc_i) begin
            if (right) w[21] = 1'b1; else w[20] = 1'b1;
        end
        if (rate_sel_i == 2'd1) w[25] = 1'b1;
        if (rate_sel_i == 2'd2) begin w[24] = 1'b1; w[25] = 1'b1; end
        w[29] = 1'b1;
        return w;
    endfunction

    function automatic string field_req(int n);
        if (n >= 32) return "R1";
        if (n < 2 || n == 6 || n == 7) return "R2";
        if (n < 6) return "R3";
        if (n < 16) return "R4";
        if (n < 24) return "R5";
        return "R6";
    endfunction

    task automatic chk(bit act, bit exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: cbit_o=%0b expected %0b (frame %0d)", req, act, exp, m_idx);
        end
    endtask

    task automatic rand_inputs();
        rate_sel_i  = 2'($urandom);
        nonaudio_i  = 1'($urandom);
        chan_dc_i   = ($urandom % 4) == 0;
        fmt_mode_i  = 1'($urandom);
        strm_copy_i = 1'($urandom);
        strm_emph_i = 3'($urandom);
        ovr_copy_i  = 1'($urandom);
        host_copy_i = 1'($urandom);
        ovr_emph_i  = 1'($urandom);
        host_emph_i = 3'($urandom);
        ovr_cat_i   = 1'($urandom);
        host_cat_i  = 8'($urandom);
    endtask

    // one frame: strobe cycle, then read left and right subframes
    task automatic do_frame(bit bs);
        @(negedge clk);
        blk_start_i = bs;
        frame_i     = !bs;
        if (bs) begin
            m_wl = exp_word(1'b0);
            m_wr = exp_word(1'b1);
            m_idx = 0;
            m_valid = 1;
        end else if (m_valid && m_idx < 191) begin
            m_idx++;
        end
        @(negedge clk);
        blk_start_i = 0;
        frame_i     = 0;
        right_i     = 0;
        #1;
        chk(cbit_o, (m_valid && m_idx < 32) ? m_wl[m_idx] : 1'b0,
            m_valid ? {field_req(m_idx), " ", m_tag, " left"} : "R1 idle");
        @(negedge clk);
        right_i = 1;
        #1;
        chk(cbit_o, (m_valid && m_idx < 32) ? m_wr[m_idx] : 1'b0,
            m_valid ? {field_req(m_idx), " ", m_tag, " right"} : "R1 idle");
    endtask

    // a block of len frames; inputs changed at frame chg (if >0) without restart
    task automatic do_block(int len, int chg);
        m_tag = "R7";
        do_frame(1'b1);
        for (int f = 1; f < len; f++) begin
            if (f == chg) begin
                rand_inputs();
                m_tag = "R8";
            end
            do_frame(1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(cbit_o, 1'b0, "R10 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cbit_o, 1'b0, "R10 after reset");
        // frames before any block start
        rand_inputs();
        repeat (4) do_frame(1'b0);

        // directed: formatter default category, 48 kHz, stream flags, full block past saturation
        rand_inputs();
        ovr_copy_i = 0; ovr_emph_i = 0; ovr_cat_i = 0; chan_dc_i = 0;
        fmt_mode_i = 1; rate_sel_i = 2'd1; strm_copy_i = 1; strm_emph_i = 3'b001;
        do_block(196, 0);

        // directed: all overrides, 32 kHz, changes mid-status
        ovr_copy_i = 1; host_copy_i = 1; ovr_emph_i = 1; host_emph_i = 3'b110;
        ovr_cat_i = 1; host_cat_i = 8'h5A; rate_sel_i = 2'd2; strm_copy_i = 0;
        do_block(40, 10);

        // directed: don't-care channel, reserved rate, early restart (R9)
        chan_dc_i = 1; rate_sel_i = 2'd3; ovr_cat_i = 0; fmt_mode_i = 0;
        do_block(20, 0);
        rand_inputs();
        m_tag = "R9";
        do_frame(1'b1);
        for (int f = 1; f < 34; f++) do_frame(1'b0);

        // random blocks
        for (int b = 0; b < 12; b++) begin
            rand_inputs();
            do_block(20 + int'($urandom % 181), ($urandom % 2) ? int'(1 + $urandom % 31) : 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule